// File: doc/BRIEF.md
# Address-Transition Gated Memory Wrapper

This block wraps a small on-chip word array and keeps it switched off except for short access windows. While the block is selected and idle, it compares the bus address with the last address it accepted. When they differ, it opens an active window of a fixed number of cycles. During that window it reads the addressed word into an output holding register. The array then drops back to standby without any help from the processor. Between windows, reads are served from the holding register.

A build parameter selects one of two variants. The read-write variant also opens a window on a write strobe. It stores the written word into the array and into the holding register. The read-only variant ignores the strobe. A free-running counter reports how many cycles the array has been enabled, so the power-gating duty cycle can be measured.

Top module: `atd_mem_wrap`

## Requirements
- R1: After reset, rdata_o is 0, busy_o is 0, en_cycles_o is 0 and the last-accepted address is 0. Array word a holds (a*29+7) truncated to DATA_W bits.
- R2: If cs_i is high, busy_o is low and addr_i differs from the last-accepted address at a rising edge, then a window starts at that edge. busy_o is then high for exactly ACT_CYC cycles, and the edge's address becomes the last-accepted address.
- R3: rdata_o changes only at the edge that closes a window. At that edge it takes the array word at the address captured when the window opened.
- R4: While cs_i is low, no window starts, rdata_o holds its value and the last-accepted address is unchanged.
- R5: An address change that arrives while busy_o is high is not lost. It is served by a window that starts at the first edge after busy_o falls.
- R6: In the read-write variant (WRITABLE=1), we_i high while selected and idle opens a window even when the address is unchanged. At the close of that window, wdata_i (captured at the start) is written to the captured address and also appears on rdata_o.
- R7: In the read-only variant (WRITABLE=0), we_i has no effect. It opens no window and does not change the array contents.
- R8: en_cycles_o goes up by one for every cycle in which busy_o is high, and wraps at its width.
- R9: A repeated access to the last-accepted address while selected, with no write, opens no window and leaves rdata_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Block select |
| we_i | input | 1 | Write strobe (read-write variant only) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Output holding register |
| busy_o | output | 1 | Array enabled (active window) |
| en_cycles_o | output | CNT_W | Count of enabled cycles |

## Verification
The assertions assume that busy_o can only rise at an edge where cs_i was high. They also assume that the window count starts from a quiet array after reset. No assumption is placed on how long the processor holds an address or a strobe. The stimulus changes inputs only on falling edges. It drops the write strobe right after the edge that opens its window, so each write produces exactly one window. Every window is allowed to close before the next vector, except in the deliberate mid-window address change.

// File: rtl/atd_pkg.sv
package atd_pkg;
  // power-up content of array word a
  function automatic logic [63:0] init_word(int unsigned a);
    return 64'(a) * 64'd29 + 64'd7;
  endfunction
endpackage

// File: rtl/atd_detect.sv
module atd_detect #(
  parameter int ADDR_W   = 6,
  parameter bit WRITABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              start_o,
  output logic              wr_o
);
  logic [ADDR_W-1:0] prev_q;
  logic              addr_diff;
  logic              wr_req;

  generate
    if (WRITABLE) begin : g_rw
      assign wr_req = we_i;
    end else begin : g_ro
      assign wr_req = 1'b0;
    end
  endgenerate

  assign addr_diff = addr_i != prev_q;
  assign start_o   = cs_i && !busy_i && (addr_diff || wr_req);
  assign wr_o      = wr_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_q <= '0;
    else if (start_o) prev_q <= addr_i;
  end
endmodule

// File: rtl/atd_gate_ctrl.sv
module atd_gate_ctrl #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int ACT_CYC = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              close_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              op_wr_o,
  output logic [DATA_W-1:0] op_wdata_o,
  output logic [CNT_W-1:0]  en_cycles_o
);
  localparam int WIN_W = $clog2(ACT_CYC + 1);

  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] en_q;

  assign busy_o      = win_q != '0;
  assign close_o     = win_q == WIN_W'(1);
  assign en_cycles_o = en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= '0;
      op_addr_o  <= '0;
      op_wr_o    <= 1'b0;
      op_wdata_o <= '0;
    end else if (start_i) begin
      win_q      <= WIN_W'(ACT_CYC);
      op_addr_o  <= addr_i;
      op_wr_o    <= wr_i;
      op_wdata_o <= wdata_i;
    end else if (busy_o) begin
      win_q <= win_q - WIN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (busy_o) en_q <= en_q + CNT_W'(1);
  end
endmodule

// File: rtl/atd_array.sv
module atd_array #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter bit WRITABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              close_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= DATA_W'(atd_pkg::init_word(i));
      rdata_o <= '0;
    end else if (en_i && close_i) begin
      if (WRITABLE && wr_i) begin
        mem_q[addr_i] <= wdata_i;
        rdata_o       <= wdata_i;
      end else begin
        rdata_o <= mem_q[addr_i];
      end
    end
  end
endmodule

// File: rtl/atd_mem_wrap.sv
module atd_mem_wrap #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int ACT_CYC  = 2,
  parameter int CNT_W    = 16,
  parameter bit WRITABLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  en_cycles_o
);
  logic              start, wr_req, close, op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;

  atd_detect #(.ADDR_W(ADDR_W), .WRITABLE(WRITABLE)) u_detect (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i),
    .addr_i(addr_i), .busy_i(busy_o), .start_o(start), .wr_o(wr_req)
  );

  atd_gate_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACT_CYC(ACT_CYC),
                  .CNT_W(CNT_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .wr_i(wr_req),
    .addr_i(addr_i), .wdata_i(wdata_i), .busy_o(busy_o), .close_o(close),
    .op_addr_o(op_addr), .op_wr_o(op_wr), .op_wdata_o(op_wdata),
    .en_cycles_o(en_cycles_o)
  );

  atd_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRITABLE(WRITABLE)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(busy_o), .close_i(close),
    .addr_i(op_addr), .wr_i(op_wr), .wdata_i(op_wdata), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/atd_mem_wrap_chk.sv
module atd_mem_wrap_chk #(
  parameter int DATA_W  = 8,
  parameter int ACT_CYC = 2,
  parameter int CNT_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              busy_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [CNT_W-1:0]  en_cycles_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 16'd1;
    else             run_q <= '0;
  end

  p_win_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < 16'(ACT_CYC));

  p_win_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> run_q == 16'(ACT_CYC));

  p_hold_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && $past(!busy_o)) |-> $stable(rdata_o));

  p_no_start_unsel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && !busy_o) |=> !busy_o);

  p_start_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(cs_i));

  p_duty_cnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_cycles_o == $past(en_cycles_o) + CNT_W'($past(busy_o)));
endmodule

bind atd_mem_wrap atd_mem_wrap_chk #(
  .DATA_W(DATA_W), .ACT_CYC(ACT_CYC), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .busy_o(busy_o),
  .rdata_o(rdata_o), .en_cycles_o(en_cycles_o)
);

// File: tb/tb_atd_mem_wrap.sv
module tb_atd_mem_wrap;
  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int ACT = 2;
  localparam int CW  = 16;
  localparam int NV  = 10;

  // {cs, we, addr[5:0], wdata[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd5,  8'h00},
    {1'b1, 1'b0, 6'd5,  8'h00},
    {1'b1, 1'b1, 6'd5,  8'hA5},
    {1'b1, 1'b0, 6'd9,  8'h00},
    {1'b0, 1'b0, 6'd20, 8'h00},
    {1'b1, 1'b0, 6'd9,  8'h00},
    {1'b1, 1'b0, 6'd5,  8'h00},
    {1'b1, 1'b1, 6'd63, 8'h3C},
    {1'b1, 1'b0, 6'd0,  8'h00},
    {1'b1, 1'b0, 6'd63, 8'h00}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, we = 0, cs_r = 0, we_r = 0;
  logic [AW-1:0] addr = '0, addr_r = '0;
  logic [DW-1:0] wd = '0, wd_r = '0, rdata, rdata_r;
  logic busy, busy_r;
  logic [CW-1:0] cnt, cnt_r;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  atd_mem_wrap #(.ADDR_W(AW), .DATA_W(DW), .ACT_CYC(ACT), .CNT_W(CW), .WRITABLE(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr), .wdata_i(wd),
    .rdata_o(rdata), .busy_o(busy), .en_cycles_o(cnt));

  atd_mem_wrap #(.ADDR_W(AW), .DATA_W(DW), .ACT_CYC(ACT), .CNT_W(CW), .WRITABLE(1'b0)) dut_rom (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs_r), .we_i(we_r), .addr_i(addr_r), .wdata_i(wd_r),
    .rdata_o(rdata_r), .busy_o(busy_r), .en_cycles_o(cnt_r));

  function automatic logic [DW-1:0] word0(int a);
    return DW'(a * 29 + 7);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DW-1:0] model [2**AW];
  logic [AW-1:0] prev;
  logic [DW-1:0] exp_rd;
  int exp_cnt;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) model[i] = word0(i);
    prev = '0; exp_rd = '0; exp_cnt = 0;
    #35 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 0);
    chk("R1 busy", busy, 0);
    chk("R1 count", cnt, 0);
    chk("R1 rom rdata", rdata_r, 0);

    for (int v = 0; v < NV; v++) begin
      logic vcs, vwe, trig;
      logic [AW-1:0] va;
      logic [DW-1:0] vd;
      {vcs, vwe, va, vd} = VEC[v];
      trig = vcs && (va != prev || vwe);
      if (trig) begin
        prev = va;
        if (vwe) model[va] = vd;
        exp_rd = model[va];
        exp_cnt += ACT;
      end
      cs = vcs; we = vwe; addr = va; wd = vd;
      @(negedge clk);
      we = 1'b0;
      chk(trig ? "R2 window opens" : "R4/R9 no window", busy, trig);
      repeat (ACT) @(negedge clk);
      chk("R2 window closed", busy, 0);
      chk(vwe ? "R6 write data latched" : "R3 read data latched", rdata, exp_rd);
      chk("R8 enabled count", cnt, exp_cnt);
    end

    // R5: address change inside a window
    cs = 1; addr = 6'd1;
    @(negedge clk);
    chk("R5 first window", busy, 1);
    addr = 6'd2;
    repeat (ACT) @(negedge clk);
    chk("R5 first word", rdata, model[1]);
    @(negedge clk);
    chk("R5 deferred window", busy, 1);
    repeat (ACT) @(negedge clk);
    chk("R5 deferred word", rdata, model[2]);
    chk("R8 count after R5", cnt, exp_cnt + 2*ACT);
    cs = 0;

    // R7: read-only variant ignores writes
    cs_r = 1; addr_r = 6'd3;
    @(negedge clk);
    repeat (ACT) @(negedge clk);
    chk("R7 rom read", rdata_r, word0(3));
    we_r = 1; wd_r = 8'hFF;
    @(negedge clk);
    chk("R7 strobe opens nothing", busy_r, 0);
    repeat (ACT) @(negedge clk);
    chk("R7 rdata kept", rdata_r, word0(3));
    addr_r = 6'd4;
    @(negedge clk);
    we_r = 0;
    repeat (ACT) @(negedge clk);
    chk("R7 no write on new addr", rdata_r, word0(4));
    addr_r = 6'd3;
    repeat (ACT + 1) @(negedge clk);
    chk("R7 contents unchanged", rdata_r, word0(3));
    chk("R8 rom count", cnt_r, 3*ACT);
    cs_r = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule